// File: doc/BRIEF.md
# AMI Line Receive Monitor

This block sits at the very front of a 1.544 Mb/s T1 receive path. It takes the two rail outputs of an alternate-mark-inversion line interface (one rail pulses for positive marks, the other for negative marks) together with the recovered receive clock. It merges the rails into one NRZ serial stream. It raises a bipolar-violation flag during the exact bit on that stream that broke the alternation rule.

A second function watches the line for a lost signal. A run of zero bit times on both rails raises a carrier-loss flag. The flag falls again only once marks have come back at a density of at least one in eight bits, held over several consecutive windows. A strap input puts the block in NRZ mode. In that mode both rails are wired to the same data and violation checking is switched off. Zero-substitution codes and frame alignment belong to later stages.

Top module: `ami_rx_monitor`

## Requirements
- R1: Both rails are captured on the falling edge of `clk_rx`. The OR of the two captured rails appears on `rx_data` at the next rising edge and is held for one full bit time.
- R2: In bipolar mode, `rx_bpv` is high for exactly the bit time in which `rx_data` shows a mark whose polarity equals that of the previous mark, with any number of zero bits allowed between them. It is low for every other bit. Positive polarity means `rail_p`=1, `rail_n`=0; negative means `rail_p`=0, `rail_n`=1.
- R3: The first single-rail mark after reset, or after leaving NRZ mode, sets the polarity reference and is not flagged.
- R4: In bipolar mode, a bit with both rails high shows as a mark on `rx_data` and is flagged on `rx_bpv`. It leaves the polarity reference unchanged.
- R5: While `nrz_mode` is high, `rx_bpv` stays low whatever the rails carry, and `rx_data` still follows the rails as in R1.
- R6: `rx_closs` rises in the same bit time as the 192nd consecutive zero bit (both rails low) on `rx_data`. A run of 191 zeros ended by a mark does not raise it.
- R7: While `rx_closs` is high, bit times are grouped into windows of 8, starting with the bit after the flag rose. A window that contains at least one mark counts as good, and a window with none resets the good count. `rx_closs` falls in the bit time that ends the third consecutive good window.
- R8: A synchronous active-high `rst` clears the rail samples, the polarity reference, the zero-run and window counters, and drives `rx_data`, `rx_bpv` and `rx_closs` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rx | input | 1 | Recovered receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| nrz_mode | input | 1 | Strap: both rails carry the same NRZ data, violation checking off |
| rail_p | input | 1 | Positive-mark rail from the line interface |
| rail_n | input | 1 | Negative-mark rail from the line interface |
| rx_data | output | 1 | Merged NRZ serial data |
| rx_bpv | output | 1 | Bipolar violation, aligned with the accused bit on `rx_data` |
| rx_closs | output | 1 | Carrier loss flag |

## Verification
Strictly alternating marks separated by zero runs of varying length show that spacing alone never raises a violation. Repeated same-polarity marks, both with and without zeros between them, show that the accused bit, and not its predecessor, is the one flagged. Double-rail marks followed by an opposite-polarity mark show that a double mark is flagged but leaves the reference alone. Identical-rail NRZ traffic, and a return to bipolar mode after it, separate suppression from a polarity reference that was reset. Zero runs of 191 and 192 bits pin down the carrier-loss threshold exactly. Recovery patterns with an empty window placed between good ones confirm that good windows must be consecutive. A long pseudo-random stream with injected errors and long silences then mixes all of these cases.

// File: rtl/ami_rx_pkg.sv
package ami_rx_pkg;

    // Captured rail pair for one bit time.
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_pair_t;

    // Line symbol decoded from a rail pair.
    typedef enum logic [1:0] {
        SYM_SPACE  = 2'b00,
        SYM_MINUS  = 2'b01,
        SYM_PLUS   = 2'b10,
        SYM_DOUBLE = 2'b11
    } line_sym_e;

    // Polarity reference kept between marks.
    typedef struct packed {
        logic valid;
        logic positive;
    } pol_ref_t;

    // One output bit of the NRZ stream with its violation flag.
    typedef struct packed {
        logic data;
        logic bpv;
    } nrz_bit_t;

    localparam int unsigned DEF_ZERO_RUN = 192;
    localparam int unsigned DEF_WIN_LEN  = 8;
    localparam int unsigned DEF_WIN_GOOD = 3;

    function automatic line_sym_e classify(rail_pair_t r);
        return line_sym_e'({r.pos, r.neg});
    endfunction

    function automatic logic is_mark(line_sym_e s);
        return s != SYM_SPACE;
    endfunction

endpackage

// File: rtl/ami_rail_sampler.sv
module ami_rail_sampler
    import ami_rx_pkg::*;
(
    input  logic       clk_rx,
    input  logic       rst,
    input  logic       rail_p,
    input  logic       rail_n,
    output rail_pair_t smp
);

    // Rails are captured on the falling edge, centred in the bit.
    always_ff @(negedge clk_rx) begin
        if (rst) begin
            smp <= '0;
        end else begin
            smp <= '{pos: rail_p, neg: rail_n};
        end
    end

endmodule

// File: rtl/ami_bpv_tracker.sv
module ami_bpv_tracker
    import ami_rx_pkg::*;
(
    input  logic       clk_rx,
    input  logic       rst,
    input  logic       nrz_mode,
    input  rail_pair_t smp,
    output nrz_bit_t   out_bit
);

    line_sym_e sym;
    pol_ref_t  pol_q;
    pol_ref_t  pol_d;
    logic      viol;

    always_comb begin
        sym   = classify(smp);
        pol_d = pol_q;
        viol  = 1'b0;
        if (nrz_mode) begin
            // Checking off; forget the reference so bipolar restarts clean.
            pol_d = '0;
        end else begin
            unique case (sym)
                SYM_PLUS: begin
                    viol  = pol_q.valid && pol_q.positive;
                    pol_d = '{valid: 1'b1, positive: 1'b1};
                end
                SYM_MINUS: begin
                    viol  = pol_q.valid && !pol_q.positive;
                    pol_d = '{valid: 1'b1, positive: 1'b0};
                end
                SYM_DOUBLE: begin
                    viol = 1'b1;
                end
                default: begin
                    viol = 1'b0;
                end
            endcase
        end
    end

    // Data and flag leave through the same register, so the flag lines up
    // with the accused bit on the serial output.
    always_ff @(posedge clk_rx) begin
        if (rst) begin
            out_bit <= '0;
            pol_q   <= '0;
        end else begin
            out_bit <= '{data: is_mark(sym), bpv: viol};
            pol_q   <= pol_d;
        end
    end

endmodule

// File: rtl/ami_carrier_mon.sv
module ami_carrier_mon
    import ami_rx_pkg::*;
#(
    parameter int unsigned ZERO_RUN = DEF_ZERO_RUN,
    parameter int unsigned WIN_LEN  = DEF_WIN_LEN,
    parameter int unsigned WIN_GOOD = DEF_WIN_GOOD
) (
    input  logic       clk_rx,
    input  logic       rst,
    input  rail_pair_t smp,
    output logic       closs
);

    localparam int unsigned ZW = $clog2(ZERO_RUN + 1);
    localparam int unsigned WW = $clog2(WIN_LEN);
    localparam int unsigned GW = $clog2(WIN_GOOD + 1);
    localparam logic [ZW-1:0] ZMAX  = ZW'(ZERO_RUN);
    localparam logic [ZW-1:0] ZLAST = ZW'(ZERO_RUN - 1);
    localparam logic [WW-1:0] WLAST = WW'(WIN_LEN - 1);
    localparam logic [GW-1:0] GLAST = GW'(WIN_GOOD - 1);

    logic          mark;
    logic          seen;
    logic [ZW-1:0] zrun;
    logic [WW-1:0] wpos;
    logic          wmark;
    logic [GW-1:0] good;

    always_comb begin
        mark = is_mark(classify(smp));
        seen = wmark | mark;
    end

    always_ff @(posedge clk_rx) begin
        if (rst) begin
            zrun  <= '0;
            closs <= 1'b0;
            wpos  <= '0;
            wmark <= 1'b0;
            good  <= '0;
        end else begin
            if (mark) begin
                zrun <= '0;
            end else if (zrun != ZMAX) begin
                zrun <= zrun + ZW'(1);
            end

            if (!closs) begin
                if (!mark && zrun == ZLAST) begin
                    closs <= 1'b1;
                    wpos  <= '0;
                    wmark <= 1'b0;
                    good  <= '0;
                end
            end else if (wpos == WLAST) begin
                wpos  <= '0;
                wmark <= 1'b0;
                if (!seen) begin
                    good <= '0;
                end else if (good == GLAST) begin
                    good  <= '0;
                    closs <= 1'b0;
                end else begin
                    good <= good + GW'(1);
                end
            end else begin
                wpos  <= wpos + WW'(1);
                wmark <= seen;
            end
        end
    end

endmodule

// File: rtl/ami_rx_monitor.sv
module ami_rx_monitor
    import ami_rx_pkg::*;
#(
    parameter int unsigned ZERO_RUN = DEF_ZERO_RUN,
    parameter int unsigned WIN_LEN  = DEF_WIN_LEN,
    parameter int unsigned WIN_GOOD = DEF_WIN_GOOD
) (
    input  logic clk_rx,
    input  logic rst,
    input  logic nrz_mode,
    input  logic rail_p,
    input  logic rail_n,
    output logic rx_data,
    output logic rx_bpv,
    output logic rx_closs
);

    rail_pair_t smp;
    nrz_bit_t   nrz_out;

    ami_rail_sampler u_smp (
        .clk_rx (clk_rx),
        .rst    (rst),
        .rail_p (rail_p),
        .rail_n (rail_n),
        .smp    (smp)
    );

    ami_bpv_tracker u_bpv (
        .clk_rx   (clk_rx),
        .rst      (rst),
        .nrz_mode (nrz_mode),
        .smp      (smp),
        .out_bit  (nrz_out)
    );

    ami_carrier_mon #(
        .ZERO_RUN (ZERO_RUN),
        .WIN_LEN  (WIN_LEN),
        .WIN_GOOD (WIN_GOOD)
    ) u_cmon (
        .clk_rx (clk_rx),
        .rst    (rst),
        .smp    (smp),
        .closs  (rx_closs)
    );

    assign rx_data = nrz_out.data;
    assign rx_bpv  = nrz_out.bpv;

endmodule

// File: rtl/ami_rx_monitor_chk.sv
module ami_rx_monitor_chk #(
    parameter int unsigned ZERO_RUN = 192
) (
    input logic clk_rx,
    input logic rst,
    input logic nrz_mode,
    input logic rx_data,
    input logic rx_bpv,
    input logic rx_closs
);

    localparam int unsigned ZW = $clog2(ZERO_RUN + 2);
    localparam logic [ZW-1:0] ZMAX  = ZW'(ZERO_RUN + 1);
    localparam logic [ZW-1:0] ZLAST = ZW'(ZERO_RUN - 1);

    // Zeros seen on the serial output up to the previous bit.
    logic [ZW-1:0] zseen;

    always_ff @(posedge clk_rx) begin
        if (rst || rx_data) begin
            zseen <= '0;
        end else if (zseen != ZMAX) begin
            zseen <= zseen + ZW'(1);
        end
    end

    // R2
    bpv_on_mark_chk: assert property (@(posedge clk_rx) disable iff (rst)
        rx_bpv |-> rx_data);

    // R5
    nrz_quiet_chk: assert property (@(posedge clk_rx) disable iff (rst)
        nrz_mode |=> !rx_bpv);

    // R6
    closs_rise_chk: assert property (@(posedge clk_rx) disable iff (rst)
        $rose(rx_closs) |-> (!rx_data && zseen >= ZLAST));

    // R8
    reset_clear_chk: assert property (@(posedge clk_rx)
        rst |=> (!rx_data && !rx_bpv && !rx_closs));

endmodule

bind ami_rx_monitor ami_rx_monitor_chk #(.ZERO_RUN(ZERO_RUN)) u_chk (
    .clk_rx   (clk_rx),
    .rst      (rst),
    .nrz_mode (nrz_mode),
    .rx_data  (rx_data),
    .rx_bpv   (rx_bpv),
    .rx_closs (rx_closs)
);

// File: tb/sim_ami_rx_monitor.sv
module sim_ami_rx_monitor;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nrz = 1'b0;
    logic rp  = 1'b0;
    logic rn  = 1'b0;
    logic rx_data, rx_bpv, rx_closs;

    always #5 clk = ~clk;

    ami_rx_monitor u0 (
        .clk_rx   (clk),
        .rst      (rst),
        .nrz_mode (nrz),
        .rail_p   (rp),
        .rail_n   (rn),
        .rx_data  (rx_data),
        .rx_bpv   (rx_bpv),
        .rx_closs (rx_closs)
    );

    typedef struct {
        int    cyc;
        logic  data;
        logic  bpv;
        logic  cls;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   nbit = 0;
    bit   done = 1'b0;

    // Bench model state.
    bit m_rv, m_rp, m_loss, m_wmark;
    int m_zrun, m_wpos, m_good;
    bit last_pos;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each expected bit once it is on the outputs.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc < cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rx_data !== e.data || rx_bpv !== e.bpv || rx_closs !== e.cls) begin
                fails++;
                $display("FAIL %s bit %0d: data/bpv/closs got %b%b%b exp %b%b%b",
                         e.tag, nbit, rx_data, rx_bpv, rx_closs, e.data, e.bpv, e.cls);
            end
            nbit++;
        end
    end

    task automatic model_clear();
        m_rv = 0; m_rp = 0; m_loss = 0; m_wmark = 0;
        m_zrun = 0; m_wpos = 0; m_good = 0;
    endtask

    // Called at rising edge + 1: drive one bit and queue its expectation.
    task automatic drive_bit(input logic p, input logic n, input string tag);
        exp_t e;
        bit mark, bpv, seen;
        mark = p | n;
        bpv  = 0;
        if (nrz) begin
            m_rv = 0;
        end else if (p && n) begin
            bpv = 1;
        end else if (p) begin
            bpv = m_rv && m_rp; m_rv = 1; m_rp = 1;
        end else if (n) begin
            bpv = m_rv && !m_rp; m_rv = 1; m_rp = 0;
        end
        // Carrier loss: set on the 192nd zero, clear after 3 good 8-bit windows.
        if (!m_loss) begin
            if (!mark && m_zrun == 191) begin
                m_loss = 1; m_wpos = 0; m_wmark = 0; m_good = 0;
            end
        end else begin
            seen = m_wmark | mark;
            if (m_wpos == 7) begin
                m_wpos = 0; m_wmark = 0;
                if (!seen) m_good = 0;
                else if (m_good == 2) begin m_good = 0; m_loss = 0; end
                else m_good++;
            end else begin
                m_wpos++; m_wmark = seen;
            end
        end
        if (mark) m_zrun = 0; else if (m_zrun < 192) m_zrun++;
        rp = p; rn = n;
        e.cyc = cyc; e.data = mark; e.bpv = bpv; e.cls = m_loss; e.tag = tag;
        q.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1; rp = 0; rn = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        model_clear();
        last_pos = 0;
        rst = 0;
        checks++;
        if (rx_data !== 1'b0 || rx_bpv !== 1'b0 || rx_closs !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset: data/bpv/closs got %b%b%b exp 000",
                     rx_data, rx_bpv, rx_closs);
        end
    endtask

    task automatic drive_zeros(input int count, input string tag);
        for (int i = 0; i < count; i++) drive_bit(0, 0, tag);
    endtask

    // Next mark with correct alternation.
    task automatic drive_mark(input string tag);
        last_pos = !last_pos;
        drive_bit(last_pos, !last_pos, tag);
    endtask

    task automatic drive_window(input bit has_mark, input string tag);
        for (int i = 0; i < 8; i++) begin
            if (has_mark && i == 3) drive_mark(tag);
            else drive_bit(0, 0, tag);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        do_reset();

        // R3: first mark sets reference without a flag
        drive_bit(0, 1, "R3");
        drive_bit(0, 0, "R3");
        drive_bit(1, 0, "R3");
        // R1: alternating marks with gaps, no flags
        drive_bit(0, 1, "R1");
        drive_bit(0, 0, "R1");
        drive_bit(0, 0, "R1");
        drive_bit(1, 0, "R1");
        drive_bit(0, 1, "R1");
        // R2: same polarity after zeros, then back to back
        drive_bit(0, 0, "R2");
        drive_bit(0, 0, "R2");
        drive_bit(0, 1, "R2");
        drive_bit(1, 0, "R2");
        drive_bit(1, 0, "R2");
        // R4: double mark flagged, reference stays positive
        drive_bit(1, 1, "R4");
        drive_bit(0, 1, "R4");
        drive_bit(1, 1, "R4");
        drive_bit(1, 0, "R4");

        // R5: NRZ traffic with repeats never flags
        nrz = 1;
        for (int i = 0; i < 40; i++) begin
            bit d;
            d = ((i * 7) % 5) < 2;
            drive_bit(d, d, "R5");
        end
        nrz = 0;
        // R3: after leaving NRZ the first mark is unflagged
        drive_bit(1, 0, "R3");
        drive_bit(1, 0, "R2");

        // R6: 191 zeros then mark, no loss; then 192 zeros, loss
        do_reset();
        drive_mark("R6");
        drive_zeros(191, "R6");
        drive_mark("R6");
        drive_zeros(192, "R6");
        drive_zeros(5, "R6");
        // R7: finish current window empty, two good, one empty, three good
        drive_zeros(3, "R7");
        drive_window(1, "R7");
        drive_window(1, "R7");
        drive_window(0, "R7");
        drive_window(1, "R7");
        drive_window(1, "R7");
        drive_window(1, "R7");
        drive_zeros(4, "R7");

        // Mixed random traffic: errors, double marks, long silences
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if ((i / 400) % 2 == 1 && (i % 400) < 230) drive_bit(0, 0, "R6");
            else if (r < 40) drive_mark("R2");
            else if (r < 44) drive_bit(last_pos, !last_pos, "R2");
            else if (r < 46) drive_bit(1, 1, "R4");
            else drive_bit(0, 0, "R7");
        end
        drive_zeros(2, "R1");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule